// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block is the part of an asynchronous DRAM controller that decides when refresh must happen and then drives the refresh strobes itself. After reset it keeps the memory idle for a fixed start-up pause. It then runs a burst of eight CAS-before-RAS refresh cycles to initialize the array. After that it raises one refresh obligation per interval, with the interval sized so that all 2048 rows are visited within the retention time of the selected grade.

Each refresh goes through a request/acknowledge handshake with the access sequencer. The scheduler raises `ref_req`, and the sequencer grants it with a one-cycle `ref_ack` once the bus is free. The scheduler then owns the RAS and CAS strobes until the cycle ends. Intervals that pass while the sequencer holds the bus for long page bursts are counted in a pending counter, up to eight, and worked off back to back.

There are two refresh styles. In the default style the device's own counter is used, with CAS falling before RAS. In the RAS-only style the block supplies the row from an 11-bit counter and keeps CAS high.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ras_n` and `cas_n` are high, `ref_req`, `addr_oe` and `init_done` are low, and `row_addr` is 0.
- R2: No request is raised during the first PAUSE_CLKS clocks after reset is released. The first request follows within a few clocks once that pause ends.
- R3: The initialization burst is exactly INIT_REFS (8) refresh cycles. All of them are CAS-before-RAS (CAS low when RAS falls), whatever the value of `ras_only_sel`.
- R4: `init_done` rises only after the eighth initialization refresh has fully completed, with both strobes high. It then stays high until reset.
- R5: In a CAS-before-RAS cycle, `cas_n` is low for exactly T_CSR clocks before `ras_n` falls and stays low for the whole T_RAS clocks that `ras_n` is low. `cas_n` is high when `ras_n` rises, and `ras_n` stays high for at least T_RP clocks before it falls again.
- R6: `ref_req` stays high until a cycle in which `ref_ack` is sampled high. `ras_n` falls only for a granted request, once per grant.
- R7: When every request is granted at once, successive requests are INT_STD clocks apart with `grade_lp`=0 and INT_LP clocks apart with `grade_lp`=1.
- R8: Intervals that pass without a refresh are kept in a pending count that saturates at PEND_MAX (8). Each completed refresh after initialization retires one.
- R9: In a RAS-only cycle, `cas_n` stays high throughout. `addr_oe` is high whenever `ras_n` is low, and `row_addr` carries the row counter.
- R10: The row counter starts at 0 and advances by one after each RAS-only refresh, wrapping from 2047 to 0. CAS-before-RAS refreshes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grade_lp | input | 1 | 0: standard retention interval, 1: low-power retention interval |
| ras_only_sel | input | 1 | 1: refresh with the internal row counter on the address bus and CAS high |
| ref_ack | input | 1 | One-cycle grant from the access sequencer |
| ref_req | output | 1 | Refresh requested, held until granted |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Drive `row_addr` onto the address bus |
| row_addr | output | ROW_W | Row counter for RAS-only refresh |
| init_done | output | 1 | Pause and initialization burst finished |

## Verification
The bench sets `ras_only_sel` high before the pause ends. A design that let the mode select leak into the initialization burst would therefore show CAS high at a RAS fall among the first eight cycles. A scoreboard pairs each grant with the refresh type and row it should produce. A row counter that skipped, advanced on CAS-before-RAS cycles, or failed to wrap after 2047 shows up as a row mismatch; a strobe without a grant shows up as an empty queue.

The bench also withholds grants for twelve intervals and then counts the refreshes that follow. A counter without saturation gives more than eight, and one that drops a tick gives fewer. Request spacing is measured in both grades, which catches a swapped or off-by-one interval. Strobe widths and CAS setup are counted per cycle.

// File: rtl/rsched_pkg.sv
package rsched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } rs_state_e;
endpackage

// File: rtl/rs_tick_gen.sv
// Start-up pause, then one tick per refresh interval.
module rs_tick_gen #(
  parameter int PAUSE_CLKS = 20000,
  parameter int INT_STD    = 1560,
  parameter int INT_LP     = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grade_lp,
  input  logic periodic_en,
  output logic pause_done,
  output logic tick
);
  localparam int INT_MAX = (INT_LP > INT_STD) ? INT_LP : INT_STD;
  localparam int TOP     = (PAUSE_CLKS > INT_MAX) ? PAUSE_CLKS : INT_MAX;
  localparam int CW      = $clog2(TOP + 1);
  localparam logic [CW-1:0] PAUSE_LIM = CW'(PAUSE_CLKS - 1);
  localparam logic [CW-1:0] STD_LIM   = CW'(INT_STD - 1);
  localparam logic [CW-1:0] LP_LIM    = CW'(INT_LP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          paused_q, paused_d;
  logic          cnt_en;
  logic [CW-1:0] limit;

  always_comb begin
    limit    = grade_lp ? LP_LIM : STD_LIM;
    cnt_d    = cnt_q;
    paused_d = paused_q;
    cnt_en   = 1'b1;
    tick     = 1'b0;
    if (!paused_q) begin
      if (cnt_q == PAUSE_LIM) begin
        paused_d = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (periodic_en) begin
      if (cnt_q >= limit) begin
        tick  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      paused_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      paused_q <= paused_d;
    end
  end

  assign pause_done = paused_q;
endmodule

// File: rtl/rs_pending.sv
// Initialization burst count and saturating pending count.
module rs_pending #(
  parameter int INIT_REFS = 8,
  parameter int PEND_MAX  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic tick,
  input  logic ref_done,
  output logic init_phase,
  output logic init_done,
  output logic need
);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [IW-1:0] INIT_LD  = IW'(INIT_REFS);
  localparam logic [PW-1:0] PEND_CAP = PW'(PEND_MAX);

  logic [IW-1:0] init_left_q, init_left_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          inc, dec;

  always_comb begin
    init_phase  = (init_left_q != '0);
    init_done   = pause_done && !init_phase;
    need        = pause_done && (init_phase || (pend_q != '0));
    init_left_d = (ref_done && init_phase) ? init_left_q - 1'b1 : init_left_q;
    inc         = tick && init_done && (pend_q != PEND_CAP);
    dec         = ref_done && !init_phase && (pend_q != '0);
    pend_d      = pend_q;
    if (inc && !dec) pend_d = pend_q + 1'b1;
    else if (dec && !inc) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_left_q <= INIT_LD;
      pend_q      <= '0;
    end else begin
      if (ref_done && init_phase) init_left_q <= init_left_d;
      if (inc != dec) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/rs_strobe.sv
// Handshake and RAS/CAS strobe sequence for one refresh.
module rs_strobe
  import rsched_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int T_CSR = 1,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             need,
  input  logic             init_phase,
  input  logic             ras_only_sel,
  input  logic             ref_ack,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             ref_done
);
  localparam int LMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                        : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int PW = $clog2(LMAX + 1);
  localparam logic [PW-1:0] CSR_M1 = PW'(T_CSR - 1);
  localparam logic [PW-1:0] RAS_M1 = PW'(T_RAS - 1);
  localparam logic [PW-1:0] RP_M1  = PW'(T_RP - 1);

  rs_state_e        st_q, st_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic             ro_q, ro_d;
  logic [ROW_W-1:0] row_q;
  logic             ph_last;

  always_comb begin
    unique case (st_q)
      ST_CAS:  ph_last = (ph_q == CSR_M1);
      ST_RAS:  ph_last = (ph_q == RAS_M1);
      ST_PRE:  ph_last = (ph_q == RP_M1);
      default: ph_last = 1'b0;
    endcase
    st_d = st_q;
    ro_d = ro_q;
    ph_d = ph_last ? '0 : ph_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        ph_d = '0;
        if (need) st_d = ST_REQ;
      end
      ST_REQ: begin
        ph_d = '0;
        if (ref_ack) begin
          ro_d = ras_only_sel && !init_phase;
          st_d = (ras_only_sel && !init_phase) ? ST_RAS : ST_CAS;
        end
      end
      ST_CAS:  if (ph_last) st_d = ST_RAS;
      ST_RAS:  if (ph_last) st_d = ST_PRE;
      ST_PRE:  if (ph_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    ref_done = (st_q == ST_PRE) && ph_last;
    ref_req  = (st_q == ST_REQ);
    ras_n    = (st_q != ST_RAS);
    cas_n    = !((st_q == ST_CAS) || ((st_q == ST_RAS) && !ro_q));
    addr_oe  = (st_q == ST_RAS) && ro_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= '0;
      ro_q  <= 1'b0;
      row_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (st_q == ST_REQ) ro_q <= ro_d;
      if (ref_done && ro_q) row_q <= row_q + 1'b1;
    end
  end

  assign row_addr = row_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CLKS = 20000,
  parameter int INT_STD    = 1560,
  parameter int INT_LP     = 6250,
  parameter int INIT_REFS  = 8,
  parameter int PEND_MAX   = 8,
  parameter int ROW_W      = 11,
  parameter int T_CSR      = 1,
  parameter int T_RAS      = 5,
  parameter int T_RP       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grade_lp,
  input  logic             ras_only_sel,
  input  logic             ref_ack,
  output logic             ref_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             init_done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       pause_done, tick, ref_done, init_phase, need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rs_tick_gen #(.PAUSE_CLKS(PAUSE_CLKS), .INT_STD(INT_STD), .INT_LP(INT_LP)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .grade_lp(grade_lp), .periodic_en(init_done),
    .pause_done(pause_done), .tick(tick));

  rs_pending #(.INIT_REFS(INIT_REFS), .PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .pause_done(pause_done), .tick(tick),
    .ref_done(ref_done), .init_phase(init_phase), .init_done(init_done), .need(need));

  rs_strobe #(.ROW_W(ROW_W), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strb (
    .clk(clk), .rst_n(rst_int_n), .need(need), .init_phase(init_phase),
    .ras_only_sel(ras_only_sel), .ref_ack(ref_ack), .ref_req(ref_req), .ras_n(ras_n),
    .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr), .ref_done(ref_done));
endmodule

// File: rtl/rsched_checker.sv
module rsched_checker #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_ack,
  input logic             ref_req,
  input logic             ras_n,
  input logic             cas_n,
  input logic             addr_oe,
  input logic [ROW_W-1:0] row_addr,
  input logic             init_done
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  assert_cbr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !addr_oe) |-> $past(!cas_n));

  assert_rasonly_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && addr_oe) |-> cas_n);

  assert_init_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_init_cbr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !addr_oe);

  assert_row_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

  assert_row_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |=> $stable(row_addr));
endmodule

bind dram_refresh_sched rsched_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req), .ras_n(ras_n),
  .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr), .init_done(init_done));

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int PAUSE = 60;
  localparam int ISTD  = 16;
  localparam int ILP   = 200;
  localparam int NINIT = 8;
  localparam int PMAX  = 8;
  localparam int RW    = 11;
  localparam int TCSR  = 1;
  localparam int TRAS  = 2;
  localparam int TRP   = 2;

  logic clk, rst_n, grade_lp, ras_only_sel, ref_ack;
  logic ref_req, ras_n, cas_n, addr_oe, init_done;
  logic [RW-1:0] row_addr;

  dram_refresh_sched #(.PAUSE_CLKS(PAUSE), .INT_STD(ISTD), .INT_LP(ILP), .INIT_REFS(NINIT),
    .PEND_MAX(PMAX), .ROW_W(RW), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) u0 (
    .clk(clk), .rst_n(rst_n), .grade_lp(grade_lp), .ras_only_sel(ras_only_sel),
    .ref_ack(ref_ack), .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n),
    .addr_oe(addr_oe), .row_addr(row_addr), .init_done(init_done));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct { bit ro; logic [RW-1:0] row; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int falls = 0, cbr_falls = 0, ro_falls = 0;
  int grants = 0;
  bit ack_en = 0, finished = 0, wrap_seen = 0;
  logic [RW-1:0] model_row = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // cycle counter and watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // driver: grants and pushes expected refreshes
  initial begin
    ref_ack = 1'b0;
    forever begin
      @(negedge clk);
      ref_ack = 1'b0;
      if (ack_en && rst_n && ref_req) begin
        exp_t e;
        e.ro  = (grants >= NINIT) ? ras_only_sel : 1'b0;
        e.row = model_row;
        if (e.ro) model_row = model_row + 1'b1;
        grants++;
        exp_q.push_back(e);
        ref_ack = 1'b1;
      end
    end
  end

  // monitor: scoreboard and strobe timing
  initial begin
    logic p_ras, p_cas, p_req, p_ack, p_init;
    int cas_run, ras_run, high_run;
    bit cur_ro;
    exp_t e;
    p_ras = 1; p_cas = 1; p_req = 0; p_ack = 0; p_init = 0;
    cas_run = 0; ras_run = 0; high_run = 1000; cur_ro = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (p_req && !p_ack) check(ref_req, "R6 request held until grant", ref_req, 1);
        if (p_ras && !ras_n) begin
          check(high_run >= TRP, "R5 precharge before RAS fall", high_run, TRP);
          if (exp_q.size() == 0) begin
            check(0, "R6 RAS fall without grant", 0, 1);
          end else begin
            e = exp_q.pop_front();
            cur_ro = e.ro;
            if (falls < NINIT) check(cas_n == 1'b0, "R3 init refresh is CBR", cas_n, 0);
            if (e.ro) begin
              check(cas_n == 1'b1, "R9 CAS high at RAS fall", cas_n, 1);
              check(addr_oe == 1'b1, "R9 address driven", addr_oe, 1);
              check(row_addr == e.row, "R10 row value", row_addr, e.row);
              if (e.row == '0 && ro_falls > 0) begin
                check(row_addr == '0, "R10 wrap 2047 to 0", row_addr, 0);
                wrap_seen = 1;
              end
              ro_falls++;
            end else begin
              check(cas_n == 1'b0, "R5 CAS low at RAS fall", cas_n, 0);
              check(cas_run == TCSR, "R5 CAS setup clocks", cas_run, TCSR);
              cbr_falls++;
            end
          end
          falls++;
        end
        if (!ras_n) begin
          if (cur_ro) check(cas_n == 1'b1, "R9 CAS high during RAS", cas_n, 1);
          else        check(cas_n == 1'b0, "R5 CAS low during RAS", cas_n, 0);
        end
        if (!p_ras && ras_n) begin
          check(ras_run == TRAS, "R5 RAS low width", ras_run, TRAS);
          check(cas_n == 1'b1, "R5 CAS high at RAS rise", cas_n, 1);
        end
        if (init_done && !p_init) begin
          check(falls == NINIT, "R4 init_done after eighth refresh", falls, NINIT);
          check(cbr_falls == NINIT, "R3 eight CBR init refreshes", cbr_falls, NINIT);
          check(ras_n && cas_n, "R4 strobes idle at init_done", {ras_n, cas_n}, 3);
        end
        if (p_init) check(init_done, "R4 init_done sticky", init_done, 1);
        cas_run  = (!cas_n && ras_n) ? cas_run + 1 : 0;
        ras_run  = !ras_n ? ras_run + 1 : 0;
        high_run = ras_n ? high_run + 1 : 0;
        p_ras = ras_n; p_cas = cas_n; p_req = ref_req; p_ack = ref_ack; p_init = init_done;
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (ref_req || !ras_n || !cas_n);
  endtask

  task automatic req_rise(output int at);
    logic prev;
    prev = ref_req;
    forever begin
      @(negedge clk);
      if (ref_req && !prev) begin at = cyc; return; end
      prev = ref_req;
    end
  endtask

  initial begin
    int a, b, c, start, quiet;
    bit early;
    rst_n = 1'b0; grade_lp = 1'b0; ras_only_sel = 1'b1;
    repeat (5) @(negedge clk);
    check(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
    check(!ref_req && !addr_oe && !init_done, "R1 req/oe/done low in reset",
          {ref_req, addr_oe, init_done}, 0);
    check(row_addr == '0, "R1 row zero", row_addr, 0);
    rst_n = 1'b1;
    ack_en = 1;
    early = 0;
    for (int i = 0; i < PAUSE; i++) begin
      @(negedge clk);
      if (ref_req || !ras_n || !cas_n) early = 1;
    end
    check(!early, "R2 no request during pause", early, 0);
    begin
      int w = 0;
      while (!ref_req && w < 8) begin @(negedge clk); w++; end
      check(ref_req || falls > 0, "R2 request after pause", ref_req, 1);
    end
    wait (init_done);
    // standard grade spacing, RAS-only rows
    req_rise(a); req_rise(b); req_rise(c);
    check(c - b == ISTD, "R7 standard interval", c - b, ISTD);
    check(b - a == ISTD, "R7 standard interval repeat", b - a, ISTD);
    // low-power grade, CBR
    wait_idle();
    ras_only_sel = 1'b0; grade_lp = 1'b1;
    req_rise(a); req_rise(b); req_rise(c);
    check(c - b == ILP, "R7 low-power interval", c - b, ILP);
    // saturation of pending count
    wait_idle();
    grade_lp = 1'b0; ack_en = 0;
    repeat (12 * ISTD) @(negedge clk);
    check(ref_req, "R6 request waits for grant", ref_req, 1);
    grade_lp = 1'b1;
    start = falls;
    ack_en = 1;
    quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      quiet = (!ref_req && ras_n) ? quiet + 1 : 0;
    end
    check(falls - start == PMAX, "R8 pending saturates at 8", falls - start, PMAX);
    // RAS-only wrap of the row counter
    wait_idle();
    grade_lp = 1'b0; ras_only_sel = 1'b1;
    wait (wrap_seen);
    repeat (3 * ISTD) @(negedge clk);
    wait_idle();
    check(wrap_seen, "R10 wrap observed", wrap_seen, 1);
    check(exp_q.size() == 0, "R6 every grant produced one refresh", exp_q.size(), 0);
    finish_run();
  end
endmodule